// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequence Controller

This block sits in front of a small SRAM that has a nonvolatile shadow copy. It watches ordinary host read accesses for a fixed six-address unlock pattern. When the pattern completes, the block starts one of two autonomous operations. A STORE copies the SRAM into the shadow array. A RECALL copies the shadow array back into the SRAM. No command register exists; the read sequence is the only trigger.

While an operation runs, the block ignores every host input, holds its read drivers off and raises a busy flag. A RECALL also starts by itself the first time the supply-good input goes true after reset. A STORE is abandoned if supply-good falls while it runs. In that case the shadow array is left as it was and a sticky abort flag is set. Both arrays are register models; the STORE and RECALL durations are clock-cycle parameters.

Top module: `nv_seq_ctrl`

## Requirements
- R1: Six consecutive selected reads at addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F start a STORE: `busy_o` is high from the cycle after the sixth access.
- R2: The same five leading addresses followed by 0x0F0E start a RECALL instead.
- R3: A selected access with `wr_i`=1 at any point of the pattern cancels it, and matching restarts from the first step.
- R4: A selected read at an address other than the next expected one resets the matcher. If that address is 0x0000, it counts as a new first step.
- R5: Cycles with `sel_i`=0 neither advance nor reset the matcher.
- R6: Every pattern access is served as a normal read of the addressed word. `oe_i` only gates `drive_o`/`rdata_o` and has no influence on matching or starting.
- R7: A STORE keeps `busy_o` high for exactly STORE_CYC cycles. At its end the shadow array takes a copy of the whole SRAM.
- R8: A RECALL keeps `busy_o` high for exactly RECALL_CYC cycles. At its end the SRAM takes a copy of the whole shadow array.
- R9: While `busy_o` is high, host writes are not applied, accesses do not advance the matcher, and `drive_o` is 0.
- R10: The first cycle after reset in which `pwr_good_i` is 1 while idle starts a RECALL. Later rises of `pwr_good_i` start none.
- R11: `pwr_good_i`=0 during a STORE ends it on the next edge without touching the shadow array, and sets `abort_o`. `abort_o` stays set until the next STORE starts. A RECALL runs on whatever `pwr_good_i` does.
- R12: After reset `busy_o`, `abort_o` and `drive_o` are 0, and both arrays hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access strobe (chip enable), active high |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| oe_i | input | 1 | Read driver enable |
| addr_i | input | AW | Word address; the arrays use the low MEM_AW bits |
| wdata_i | input | DW | Write data |
| pwr_good_i | input | 1 | Supply-good indication |
| rdata_o | output | DW | Read data, zero when not driven |
| drive_o | output | 1 | Read data drivers on (0 models high impedance) |
| busy_o | output | 1 | STORE or RECALL in progress |
| abort_o | output | 1 | Sticky: last STORE was aborted |

## Verification
The checker watches several rules on every cycle: drivers stay off while busy, the matcher stays in range and holds still when unselected, a write clears it, an abort happens on the edge after supply loss, a RECALL does not stop early, neither operation outlasts its cycle count, and the abort flag stays set. What the arrays hold after a STORE, a RECALL or an abort can only be shown by the bench's scenarios, which read the data back through the host port. The same holds for the restart on 0x0000, the one-time power-up recall and writes being dropped while busy.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  localparam int unsigned SEQ_LEN = 6;
  localparam logic [12:0] ADDR_STORE  = 13'h0F0F;
  localparam logic [12:0] ADDR_RECALL = 13'h0F0E;

  typedef enum logic [1:0] {OP_IDLE, OP_STORE, OP_RECALL} op_e;

  // leading unlock addresses, steps 0..4
  function automatic logic [12:0] lead_addr(input logic [2:0] idx);
    case (idx)
      3'd0:    return 13'h0000;
      3'd1:    return 13'h1555;
      3'd2:    return 13'h0AAA;
      3'd3:    return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction
endpackage

// File: rtl/nv_seq_matcher.sv
module nv_seq_matcher
  import nv_seq_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          go_store_o,
  output logic          go_recall_o,
  output logic [2:0]    step_o
);
  localparam logic [2:0] LAST = 3'(SEQ_LEN - 1);

  logic [2:0] step_q;
  logic       lead_hit, last_st, last_rc, is_zero;

  assign lead_hit = (step_q != LAST) && (addr_i == AW'(lead_addr(step_q)));
  assign last_st  = (step_q == LAST) && (addr_i == AW'(ADDR_STORE));
  assign last_rc  = (step_q == LAST) && (addr_i == AW'(ADDR_RECALL));
  assign is_zero  = (addr_i == '0);

  assign go_store_o  = acc_i && !wr_i && last_st;
  assign go_recall_o = acc_i && !wr_i && last_rc;
  assign step_o      = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
    end else if (acc_i) begin
      if (wr_i)                  step_q <= '0;
      else if (lead_hit)         step_q <= step_q + 3'd1;
      else if (last_st || last_rc) step_q <= '0;
      else                       step_q <= is_zero ? 3'd1 : 3'd0;
    end
  end
endmodule

// File: rtl/nv_seq_engine.sv
module nv_seq_engine
  import nv_seq_pkg::*;
#(
  parameter int unsigned STORE_CYC  = 500000,
  parameter int unsigned RECALL_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic go_store_i,
  input  logic go_recall_i,
  output op_e  op_o,
  output logic busy_o,
  output logic abort_o,
  output logic commit_store_o,
  output logic commit_recall_o
);
  localparam int unsigned MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  op_e           op_q;
  logic [CW-1:0] cnt_q;
  logic          abort_q, pu_done_q;

  assign op_o            = op_q;
  assign busy_o          = (op_q != OP_IDLE);
  assign abort_o         = abort_q;
  assign commit_store_o  = (op_q == OP_STORE) && pwr_good_i && (cnt_q == '0);
  assign commit_recall_o = (op_q == OP_RECALL) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      cnt_q     <= '0;
      abort_q   <= 1'b0;
      pu_done_q <= 1'b0;
    end else begin
      case (op_q)
        OP_IDLE: begin
          if (pwr_good_i && !pu_done_q) begin
            op_q      <= OP_RECALL;
            cnt_q     <= CW'(RECALL_CYC - 1);
            pu_done_q <= 1'b1;
          end else if (go_store_i) begin
            op_q    <= OP_STORE;
            cnt_q   <= CW'(STORE_CYC - 1);
            abort_q <= 1'b0;
          end else if (go_recall_i) begin
            op_q  <= OP_RECALL;
            cnt_q <= CW'(RECALL_CYC - 1);
          end
        end
        OP_STORE: begin
          if (!pwr_good_i) begin
            op_q    <= OP_IDLE;
            abort_q <= 1'b1;
          end else if (cnt_q == '0) op_q <= OP_IDLE;
          else                      cnt_q <= cnt_q - 1'b1;
        end
        default: begin
          if (cnt_q == '0) op_q <= OP_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nv_seq_arrays.sv
module nv_seq_arrays #(
  parameter int unsigned DW     = 8,
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              commit_store_i,
  input  logic              commit_recall_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int unsigned DEPTH = 1 << MEM_AW;

  logic [DW-1:0] sram_q   [DEPTH];
  logic [DW-1:0] shadow_q [DEPTH];

  assign rdata_o = sram_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        sram_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      if (commit_recall_i) begin
        for (int i = 0; i < DEPTH; i++) sram_q[i] <= shadow_q[i];
      end else if (wr_en_i) begin
        sram_q[addr_i] <= wdata_i;
      end
      if (commit_store_i) begin
        for (int i = 0; i < DEPTH; i++) shadow_q[i] <= sram_q[i];
      end
    end
  end
endmodule

// File: rtl/nv_seq_ctrl.sv
module nv_seq_ctrl
  import nv_seq_pkg::*;
#(
  parameter int unsigned AW         = 13,
  parameter int unsigned DW         = 8,
  parameter int unsigned MEM_AW     = 8,
  parameter int unsigned STORE_CYC  = 500000,
  parameter int unsigned RECALL_CYC = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          oe_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pwr_good_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o,
  output logic          busy_o,
  output logic          abort_o
);
  logic          acc, go_st, go_rc, cm_st, cm_rc;
  logic [2:0]    step_q;
  op_e           op_q;
  logic [DW-1:0] mem_rd;

  assign acc     = sel_i && !busy_o;
  assign drive_o = acc && !wr_i && oe_i;
  assign rdata_o = drive_o ? mem_rd : '0;

  nv_seq_matcher #(.AW(AW)) u_match (
    .clk_i, .rst_ni,
    .acc_i(acc), .wr_i, .addr_i,
    .go_store_o(go_st), .go_recall_o(go_rc), .step_o(step_q)
  );

  nv_seq_engine #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_eng (
    .clk_i, .rst_ni, .pwr_good_i,
    .go_store_i(go_st), .go_recall_i(go_rc),
    .op_o(op_q), .busy_o, .abort_o,
    .commit_store_o(cm_st), .commit_recall_o(cm_rc)
  );

  nv_seq_arrays #(.DW(DW), .MEM_AW(MEM_AW)) u_arr (
    .clk_i, .rst_ni,
    .wr_en_i(acc && wr_i), .addr_i(addr_i[MEM_AW-1:0]), .wdata_i,
    .commit_store_i(cm_st), .commit_recall_i(cm_rc),
    .rdata_o(mem_rd)
  );
endmodule

// File: rtl/nv_seq_chk.sv
module nv_seq_chk
  import nv_seq_pkg::*;
#(
  parameter int unsigned STORE_CYC  = 500000,
  parameter int unsigned RECALL_CYC = 1000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       wr_i,
  input logic       pwr_good_i,
  input logic       drive_o,
  input logic       busy_o,
  input logic       abort_o,
  input op_e        op_q,
  input logic [2:0] step_q
);
  int unsigned run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  p_hiz_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !drive_o);
  p_step_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= 3'(SEQ_LEN - 1));
  p_wr_cancel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && !busy_o) |=> step_q == 3'd0);
  p_unsel_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !busy_o) |=> $stable(step_q));
  p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_STORE && !pwr_good_i) |=> (!busy_o && abort_o));
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (abort_o || op_q == OP_STORE));
  p_recall_runs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_RECALL && run_cnt + 1 < RECALL_CYC) |=> busy_o);
  p_recall_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_RECALL) |-> run_cnt < RECALL_CYC);
  p_store_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_STORE) |-> run_cnt < STORE_CYC);
endmodule

bind nv_seq_ctrl nv_seq_chk #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
  .pwr_good_i(pwr_good_i), .drive_o(drive_o), .busy_o(busy_o),
  .abort_o(abort_o), .op_q(op_q), .step_q(step_q)
);

// File: tb/tb_nv_seq_ctrl.sv
module tb_nv_seq_ctrl;
  localparam int AW = 13, DW = 8, MAW = 6, SC = 40, RC = 12;
  localparam int DEPTH = 1 << MAW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, wr = 0, oe = 0, pg = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic drive, busy, abort;

  always #10 clk = ~clk;

  nv_seq_ctrl #(.AW(AW), .DW(DW), .MEM_AW(MAW), .STORE_CYC(SC), .RECALL_CYC(RC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .oe_i(oe),
    .addr_i(addr), .wdata_i(wdata), .pwr_good_i(pg),
    .rdata_o(rdata), .drive_o(drive), .busy_o(busy), .abort_o(abort)
  );

  int total = 0, bad = 0;
  string cur_req = "R12";

  // reference model
  logic [DW-1:0] sram_m [DEPTH];
  logic [DW-1:0] shad_m [DEPTH];
  int  step_m = 0, left_m = 0, op_m = 0; // op: 0 idle 1 store 2 recall
  bit  abort_m = 0, pu_m = 0;

  function automatic logic [12:0] seq_addr(int i);
    case (i)
      0: return 13'h0000; 1: return 13'h1555; 2: return 13'h0AAA;
      3: return 13'h1FFF; default: return 13'h10F0;
    endcase
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int go = 0;
    if (op_m != 0) begin
      if (op_m == 1 && !pg) begin op_m = 0; abort_m = 1; end
      else if (left_m == 1) begin
        for (int i = 0; i < DEPTH; i++)
          if (op_m == 1) shad_m[i] = sram_m[i]; else sram_m[i] = shad_m[i];
        op_m = 0;
      end else left_m--;
    end else begin
      if (sel) begin
        if (wr) begin step_m = 0; sram_m[addr[MAW-1:0]] = wdata; end
        else if (step_m < 5 && addr == seq_addr(step_m)) step_m++;
        else if (step_m == 5 && addr == 13'h0F0F) begin go = 1; step_m = 0; end
        else if (step_m == 5 && addr == 13'h0F0E) begin go = 2; step_m = 0; end
        else step_m = (addr == 0) ? 1 : 0;
      end
      if (pg && !pu_m) begin op_m = 2; left_m = RC; pu_m = 1; end
      else if (go == 1) begin op_m = 1; left_m = SC; abort_m = 0; end
      else if (go == 2) begin op_m = 2; left_m = RC; end
    end
  endtask

  task automatic cyc(bit s, bit w, logic [AW-1:0] a, logic [DW-1:0] d, bit o, bit p);
    bit exp_drv;
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d; oe = o; pg = p;
    #1;
    exp_drv = s && !w && o && (op_m == 0);
    chk(busy == (op_m != 0), "busy", busy, op_m != 0);
    chk(abort == abort_m, "abort", abort, abort_m);
    chk(drive == exp_drv, "drive", drive, exp_drv);
    if (exp_drv) chk(rdata == sram_m[a[MAW-1:0]], "rdata", rdata, sram_m[a[MAW-1:0]]);
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(int n, bit p);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, 0, p);
  endtask

  task automatic pat(logic [12:0] last, bit o);
    for (int i = 0; i < 5; i++) cyc(1, 0, seq_addr(i), '0, o, 1);
    cyc(1, 0, last, '0, o, 1);
  endtask

  task automatic fill();
    for (int i = 0; i < DEPTH; i++) cyc(1, 1, AW'(i), DW'($urandom), 0, 1);
  endtask

  task automatic readall();
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, AW'(i + DEPTH), '0, 1, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL %s watchdog actual=hung expected=done", cur_req);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) begin sram_m[i] = '0; shad_m[i] = '0; end
    // R12 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !abort && !drive, "reset outputs", {busy, abort, drive}, 0);
    rst_n = 1;
    idle(2, 0);
    for (int i = 0; i < 8; i++) cyc(1, 0, AW'(i), '0, 1, 0);
    // R10 writes before supply good, then power-up recall clears them
    cur_req = "R10";
    for (int i = 0; i < 8; i++) cyc(1, 1, AW'(i), DW'(8'hA0 + i), 0, 0);
    idle(3, 0);
    idle(RC + 3, 1);
    for (int i = 0; i < 8; i++) cyc(1, 0, AW'(i), '0, 1, 1);
    idle(3, 0); idle(3, 1);
    chk(!busy, "no second power-up recall", busy, 0);
    // R1 R6 store via pattern with oe low, then R9 traffic while busy
    cur_req = "R6"; fill();
    cur_req = "R1"; pat(13'h0F0F, 0);
    cur_req = "R9";
    for (int i = 0; i < SC + 4; i++) cyc(1, $urandom % 2, AW'($urandom), DW'($urandom), 1, 1);
    // R2 R7 R8 overwrite then recall restores stored image
    cur_req = "R6"; fill();
    cur_req = "R2"; pat(13'h0F0E, 1);
    cur_req = "R8"; idle(RC + 2, 1);
    cur_req = "R7"; readall();
    // R3 write inside pattern cancels
    cur_req = "R3";
    for (int i = 0; i < 3; i++) cyc(1, 0, seq_addr(i), '0, 1, 1);
    cyc(1, 1, seq_addr(3), 8'h5A, 0, 1);
    cyc(1, 0, seq_addr(4), '0, 1, 1);
    cyc(1, 0, 13'h0F0F, '0, 1, 1);
    idle(2, 1);
    chk(!busy, "cancelled pattern started op", busy, 0);
    // R4 mismatch on 0x0000 restarts as step 1
    cur_req = "R4";
    cyc(1, 0, 13'h0000, '0, 1, 1); cyc(1, 0, 13'h1555, '0, 1, 1);
    cyc(1, 0, 13'h0000, '0, 1, 1); cyc(1, 0, 13'h1555, '0, 1, 1);
    cyc(1, 0, 13'h0AAA, '0, 1, 1); cyc(1, 0, 13'h1FFF, '0, 1, 1);
    cyc(1, 0, 13'h10F0, '0, 1, 1); cyc(1, 0, 13'h0F0F, '0, 1, 1);
    idle(SC + 2, 1);
    // R5 unselected junk interleaved
    cur_req = "R5";
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, i < 5 ? seq_addr(i) : 13'h0F0E, '0, 1, 1);
      cyc(0, 1, 13'h0333, 8'hEE, 1, 1);
    end
    idle(RC + 2, 1);
    // R11 store abort keeps shadow, flag sticky
    cur_req = "R11"; fill();
    pat(13'h0F0F, 1);
    idle(5, 1); idle(1, 0); idle(4, 1);
    chk(abort, "abort flag", abort, 1);
    fill();
    pat(13'h0F0E, 1);
    idle(2, 1); idle(RC, 0); idle(2, 1);
    readall();
    // random phase
    cur_req = "R9";
    for (int n = 0; n < 3000; n++) begin
      bit s = ($urandom % 4) != 0;
      bit w = ($urandom % 8) == 0;
      logic [AW-1:0] a;
      int k = $urandom % 7;
      if ($urandom % 2) a = (k < 5) ? seq_addr(k) : (k == 5 ? 13'h0F0F : 13'h0F0E);
      else a = AW'($urandom);
      cyc(s, w, a, DW'($urandom), $urandom % 2, 1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule